// File: doc/BRIEF.md
# Per-Channel Control Bit Serializer

This block drives an auxiliary serial line of a time-division switch. The line runs at the same 2.048 Mb/s bit rate as the switch's data outputs, so a 125 µs frame holds 256 bit periods. Each bit period carries one control flag, and the frame carries one flag for every pair of output stream and output channel (8 streams by 32 channels). The flags live in a per-channel control memory. This block only reads that memory. The memory returns the control bit of the addressed byte one clock after a read, and the block serializes these bits.

The bits run one channel ahead of the data outputs. This gives external control circuits a full slot to act before the matching data appears. Inside the slot of data channel c, the line carries the flags of channel c+1, one per stream, with stream 0 in the first (most significant) bit period and stream 7 in the last. Channel 0's flags therefore go out during the slot of channel 31, which wraps across the frame boundary.

Bit timing comes from a frame-counter strobe, and a frame pulse marks the start of channel 0. A flag byte group is read from memory during the slot before it is sent and is held in a staging register. It moves to an output shift register at the slot boundary.

Top module: `ccs_serializer`

## Requirements
- R1: After synchronous reset, `ctl_o` and `rd_en` are 0. Both stay 0 through any number of `bit_stb` strobes until the first strobe that arrives with `frame_sync` high.
- R2: A strobe with `frame_sync` high sets the position to bit period 0 of channel slot 0. Without further pulses, the position steps once per strobe and wraps from slot 31 period 7 back to slot 0 period 0, so every 256 strobes repeat the same sequence.
- R3: In bit period s (0..7) of slot c, `ctl_o` equals the control bit stored at memory address s*32 + ((c+1) mod 32), that is {stream[2:0], channel[4:0]}. Bit period 0 is the first period of a slot.
- R4: In slot 31, the line carries channel 0's flags: stream 0 in the first period of slot 31, and stream s in period s.
- R5: During the first slot after the first frame pulse following reset, `ctl_o` is 0 because nothing has been staged yet. Correct data starts with slot 1.
- R6: `ctl_o` changes only on the second clock edge after a strobe and holds its value until the next such edge.
- R7: During each slot c, the block issues exactly eight single-cycle reads on consecutive clocks, for streams 0 to 7 of channel (c+2) mod 32. Their results are sent in slot c+1, so memory changes made after the reads do not affect that slot. Strobes must be at least 2 clocks apart.
- R8: A synchronous reset asserted in the middle of a frame returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_stb | input | 1 | One-clock strobe at the start of each serial bit period |
| frame_sync | input | 1 | Frame pulse, valid together with `bit_stb`, marks slot 0 period 0 |
| rd_en | output | 1 | Control memory read request |
| rd_addr | output | 8 | Read address {stream, channel} |
| rd_data | input | 1 | Control bit of the addressed byte, one clock after `rd_en` |
| ctl_o | output | 1 | Serial control bit line |

## Verification
Two events land on the same clock edge at every slot boundary: the staged flags for the new slot are loaded into the shift register, and the fetch for the following slot restarts and begins to overwrite the staging register. To provoke this, the bench flips the control bits of the channel now being shifted out and of the channel already staged in the middle of a slot, after that slot's reads are complete. It then checks that these two slots still carry the old values and that the next frame carries the new ones. Running frames without frame pulses also exercises the wrap from slot 31 to slot 0, together with the same boundary load.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  // slots between the slot being fetched and the slot being shifted out now
  localparam int FETCH_AHEAD = 2;

  function automatic int wrap_add(input int v, input int k, input int n);
    return (v + k) % n;
  endfunction
endpackage

// File: rtl/ccs_timebase.sv
module ccs_timebase #(
  parameter int STREAMS  = 8,
  parameter int CHANNELS = 32,
  localparam int STR_W   = $clog2(STREAMS),
  localparam int CH_W    = $clog2(CHANNELS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb,
  input  logic             frame_sync,
  output logic             adv,
  output logic             synced,
  output logic [STR_W-1:0] period,
  output logic [CH_W-1:0]  chan
);
  localparam logic [STR_W-1:0] LAST_P = STR_W'(STREAMS - 1);
  localparam logic [CH_W-1:0]  LAST_C = CH_W'(CHANNELS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      adv    <= 1'b0;
      synced <= 1'b0;
      period <= '0;
      chan   <= '0;
    end else begin
      adv <= 1'b0;
      if (bit_stb) begin
        if (frame_sync) begin
          synced <= 1'b1;
          adv    <= 1'b1;
          period <= '0;
          chan   <= '0;
        end else if (synced) begin
          adv <= 1'b1;
          if (period == LAST_P) begin
            period <= '0;
            chan   <= (chan == LAST_C) ? '0 : chan + 1'b1;
          end else begin
            period <= period + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ccs_fetch.sv
module ccs_fetch #(
  parameter int STREAMS  = 8,
  parameter int CHANNELS = 32,
  localparam int STR_W   = $clog2(STREAMS),
  localparam int CH_W    = $clog2(CHANNELS),
  localparam int ADDR_W  = STR_W + CH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CH_W-1:0]   cur_chan,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_data,
  output logic [STREAMS-1:0] stage
);
  localparam logic [STR_W-1:0] LAST_S = STR_W'(STREAMS - 1);

  logic             busy;
  logic [STR_W-1:0] idx;
  logic [CH_W-1:0]  tgt;
  logic             cap_en;
  logic [STR_W-1:0] cap_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      idx     <= '0;
      tgt     <= '0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
      cap_en  <= 1'b0;
      cap_idx <= '0;
      stage   <= '0;
    end else begin
      rd_en   <= 1'b0;
      cap_en  <= rd_en;
      cap_idx <= rd_addr[ADDR_W-1 -: STR_W];
      if (cap_en) stage[cap_idx] <= rd_data;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
        tgt  <= CH_W'(ccs_pkg::wrap_add(int'(cur_chan), ccs_pkg::FETCH_AHEAD, CHANNELS));
      end else if (busy) begin
        rd_en   <= 1'b1;
        rd_addr <= {idx, tgt};
        idx     <= idx + 1'b1;
        if (idx == LAST_S) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ccs_shifter.sv
module ccs_shifter #(
  parameter int STREAMS = 8,
  localparam int STR_W  = $clog2(STREAMS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic [STR_W-1:0]   period,
  input  logic [STREAMS-1:0] stage,
  output logic               ctl
);
  logic [STREAMS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      ctl <= 1'b0;
    end else if (adv) begin
      if (period == '0) begin
        ctl <= stage[0];
        sh  <= stage >> 1;
      end else begin
        ctl <= sh[0];
        sh  <= sh >> 1;
      end
    end
  end
endmodule

// File: rtl/ccs_serializer.sv
module ccs_serializer #(
  parameter int STREAMS  = 8,
  parameter int CHANNELS = 32,
  localparam int STR_W   = $clog2(STREAMS),
  localparam int CH_W    = $clog2(CHANNELS),
  localparam int ADDR_W  = STR_W + CH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              frame_sync,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_data,
  output logic              ctl_o
);
  logic               adv;
  logic               synced;
  logic [STR_W-1:0]   period;
  logic [CH_W-1:0]    chan;
  logic [STREAMS-1:0] stage;
  logic               slot_start;

  assign slot_start = adv && (period == '0);

  ccs_timebase #(.STREAMS(STREAMS), .CHANNELS(CHANNELS)) u_tb (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .frame_sync(frame_sync),
    .adv(adv), .synced(synced), .period(period), .chan(chan)
  );

  ccs_fetch #(.STREAMS(STREAMS), .CHANNELS(CHANNELS)) u_fetch (
    .clk(clk), .rst(rst), .start(slot_start), .cur_chan(chan),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .stage(stage)
  );

  ccs_shifter #(.STREAMS(STREAMS)) u_shift (
    .clk(clk), .rst(rst), .adv(adv), .period(period), .stage(stage), .ctl(ctl_o)
  );
endmodule

// File: rtl/ccs_serializer_chk.sv
module ccs_serializer_chk #(
  parameter int STR_W  = 3,
  parameter int CH_W   = 5,
  parameter int LAST_S = 7
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  ctl_o,
  input logic                  rd_en,
  input logic [STR_W+CH_W-1:0] rd_addr,
  input logic                  adv,
  input logic                  synced
);
  logic [STR_W-1:0] rd_str;
  logic [CH_W-1:0]  rd_ch;
  assign rd_str = rd_addr[STR_W+CH_W-1 -: STR_W];
  assign rd_ch  = rd_addr[CH_W-1:0];

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !synced |-> (!ctl_o && !rd_en)); // R1
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ctl_o)); // R6
  AST_BURST_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_en) |-> (rd_str == '0)); // R7
  AST_BURST_END: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_str == STR_W'(LAST_S)) |=> !rd_en); // R7
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_str != STR_W'(LAST_S)) |=> (rd_en && rd_str == $past(rd_str) + 1'b1)); // R7
  AST_BURST_CHAN: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |-> (rd_ch == $past(rd_ch))); // R7
endmodule

bind ccs_serializer ccs_serializer_chk #(.STR_W(STR_W), .CH_W(CH_W), .LAST_S(STREAMS - 1)) u_chk (
  .clk(clk), .rst(rst), .ctl_o(ctl_o), .rd_en(rd_en), .rd_addr(rd_addr),
  .adv(adv), .synced(synced)
);

// File: tb/ccs_serializer_tb.sv
module ccs_serializer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_stb = 1'b0;
  logic       frame_sync = 1'b0;
  logic       rd_en;
  logic [7:0] rd_addr;
  logic       rd_data = 1'b0;
  logic       ctl_o;

  logic [7:0] mem     [256];
  logic [7:0] ref_mem [256];
  int checks = 0;
  int fails  = 0;
  int reads_seen = 0;
  logic prev = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  ccs_serializer u_dut (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .frame_sync(frame_sync),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ctl_o(ctl_o)
  );

  // control memory model: bit 1 of the addressed byte, one clock after the read
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data    <= mem[rd_addr][1];
      reads_seen <= reads_seen + 1;
    end
  end

  // {resync each frame, fill mode[1:0], seed[7:0]}
  localparam logic [10:0] VEC [4] = '{
    {1'b1, 2'd0, 8'h00},
    {1'b0, 2'd1, 8'h00},
    {1'b1, 2'd2, 8'h5A},
    {1'b0, 2'd2, 8'hC3}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; bit_stb = 1'b0; frame_sync = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    prev = 1'b0;
  endtask

  // one bit period of 4 clocks; early sample before the output edge, late after it
  task automatic do_period(input bit fp, output logic e, output logic l);
    bit_stb = 1'b1; frame_sync = fp;
    @(negedge clk);
    bit_stb = 1'b0; frame_sync = 1'b0;
    e = ctl_o;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    l = ctl_o;
  endtask

  task automatic fill(input logic [1:0] mode, input logic [7:0] seed);
    for (int a = 0; a < 256; a++) begin
      case (mode)
        2'd0:    mem[a] = 8'h00;
        2'd1:    mem[a] = 8'hFF;
        default: mem[a] = 8'(a * (seed | 8'h01) + seed) ^ 8'(a >> 2);
      endcase
      ref_mem[a] = mem[a];
    end
  endtask

  task automatic flip_67(input bit in_ref);
    for (int s = 0; s < 8; s++) begin
      if (in_ref) begin
        ref_mem[s*32+6] ^= 8'h02; ref_mem[s*32+7] ^= 8'h02;
      end else begin
        mem[s*32+6] ^= 8'h02; mem[s*32+7] ^= 8'h02;
      end
    end
  endtask

  task automatic run_frame(input bit first, input bit pulse, input int hook);
    logic e, l, expv;
    for (int p = 0; p < 256; p++) begin
      int c = p / 8;
      int s = p % 8;
      string tag;
      do_period(pulse && (p == 0), e, l);
      if (first && c == 0) begin
        expv = 1'b0; tag = "R5 first slot";
      end else begin
        expv = ref_mem[s*32 + ((c + 1) % 32)][1];
        tag = (c == 31) ? "R4 wrap slot" : (pulse ? "R3 bit order" : "R2 free-running wrap");
      end
      if (hook >= 0 && c >= 5 && c <= 6) tag = "R7 preloaded slot";
      chk(l === expv, tag, int'(l), int'(expv));
      chk(e === prev, "R6 hold until second edge", int'(e), int'(prev));
      prev = l;
      if (p == hook) flip_67(1'b0);
      if (hook >= 0 && p == 55) flip_67(1'b1);
    end
  endtask

  initial begin
    logic e, l;
    int r0;
    do_reset();
    chk(ctl_o === 1'b0, "R1 reset ctl_o", int'(ctl_o), 0);
    chk(rd_en === 1'b0, "R1 reset rd_en", int'(rd_en), 0);
    fill(2'd1, 8'h00);
    for (int i = 0; i < 12; i++) begin
      do_period(1'b0, e, l);
      chk(l === 1'b0, "R1 low before first pulse", int'(l), 0);
    end
    chk(reads_seen == 0, "R1 no reads before first pulse", reads_seen, 0);

    for (int v = 0; v < 4; v++) begin
      do_reset();
      fill(VEC[v][9:8], VEC[v][7:0]);
      run_frame(1'b1, 1'b1, -1);
      run_frame(1'b0, VEC[v][10], -1);
      run_frame(1'b0, VEC[v][10], -1);
    end

    // R7: change staged and shifting flags after their reads
    run_frame(1'b0, 1'b1, 44);
    run_frame(1'b0, 1'b1, -1);

    // R8: reset in mid frame
    for (int i = 0; i < 100; i++) do_period(1'b0, e, l);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(ctl_o === 1'b0, "R8 mid-frame reset ctl_o", int'(ctl_o), 0);
    chk(rd_en === 1'b0, "R8 mid-frame reset rd_en", int'(rd_en), 0);
    r0 = reads_seen;
    for (int i = 0; i < 10; i++) begin
      do_period(1'b0, e, l);
      chk(l === 1'b0, "R8 low until pulse", int'(l), 0);
    end
    chk(reads_seen == r0, "R8 no reads until pulse", reads_seen, r0);
    prev = 1'b0;
    run_frame(1'b1, 1'b1, -1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule